// File: doc/BRIEF.md
# Arithmetic-Progression Color Inference Unit

This block does one pass of constraint propagation for a coloring search. The search gives every position of a fixed array of variables a small mask of the colors that position may still take. The search must never fix one color on all members of an evenly spaced run (an arithmetic progression) of a given length. The caller presents the whole mask array, picks one color and pulses a start strobe. The unit looks at every progression of the forbidden length for that color that fits in the array. It returns a narrowed mask array, a flag that says whether anything was narrowed, and a flag that says the present state cannot be completed.

Colors are one-hot bits in each mask. A variable is forced to a color when its mask holds only that color's bit. If all but one member of some progression are forced to the selected color, the remaining member cannot take that color, so its bit is cleared. If every member is already forced, or if any variable is left with no color at all, the pass reports a conflict. Each color has its own forbidden length, so instances where the colors have different bounds are supported. The search logic above the unit repeats passes over the colors until none changes anything, and it backtracks on a conflict. That search is not part of this block.

Top module: `apInferUnit`

## Requirements
- R1: While reset is held and after it is released, maskOut, changed, conflict and done are all zero until the first start.
- R2: A start sampled at a clock edge produces the results and a one-cycle done pulse at that same edge, so they are visible one cycle after start. Without start, maskOut, changed and conflict keep their values.
- R3: Variable i (0 to NUM_VARS-1) uses maskIn bits [i*NUM_COLORS +: NUM_COLORS], and bit c of that slice means color c is still allowed. A variable is forced to c when its slice equals 1 << c.
- R4: For selected color c with length Lc, a progression is a set of positions s, s+d, ..., s+(Lc-1)d with d >= 1, all inside the array. If Lc-1 of its members are forced to c and the remaining member is not forced but allows c, bit c of that member is cleared in maskOut.
- R5: A pass only clears bits. It never sets a bit, and it never changes any bit other than bit c of the selected color.
- R6: changed is high exactly when maskOut differs from the maskIn sampled with start.
- R7: conflict is high when some progression of length Lc has all of its members forced to c.
- R8: conflict is high when any variable's mask in maskOut is zero, including a mask that was already zero on input.
- R9: Each color uses its own length from PROG_LEN (byte c holds Lc). With lengths 3, 4 and 5 for colors 0, 1 and 2, two forced neighbours clear their next neighbour for color 0 but not for color 1.
- R10: A colorSel value of NUM_COLORS or more passes maskIn through unchanged with changed low. conflict then reflects only zero masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run one inference pass on the present inputs |
| colorSel | input | COLOR_W | Index of the color to check |
| maskIn | input | NUM_VARS*NUM_COLORS | Candidate color masks, one slice per variable |
| maskOut | output | NUM_VARS*NUM_COLORS | Narrowed masks from the last pass |
| changed | output | 1 | Last pass cleared at least one bit |
| conflict | output | 1 | Last pass found a forced progression or an empty mask |
| done | output | 1 | One-cycle pulse, results updated |

## Verification
The directed patterns each separate one rule from the others. Two forced neighbours followed by a free variable test the basic clear and also which end of the array is used. The same pattern repeated for another color shows that the per-color length is applied. A spaced triple of forced variables checks full-progression detection for a step larger than one, and an empty mask checks the second conflict source. An out-of-range color select must leave everything untouched. Random arrays that lean toward forced masks then give many overlapping progressions for all colors, where a wrong step range, a missed start position or a clear of the wrong bit would differ from the bench model. Changing inputs without start checks that the outputs hold.

// File: rtl/apInferPkg.sv
package apInferPkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture the combinational result of this cycle
  } apStrobe_t;

endpackage

// File: rtl/apProgScan.sv
// Scans every progression of a fixed length over the forced / allowed
// vectors of one color and reports clear candidates and full hits.
module apProgScan #(
  parameter int NUM_VARS = 32,
  parameter int PROG_LEN = 4
) (
  input  logic [NUM_VARS-1:0] forced,
  input  logic [NUM_VARS-1:0] allow,
  output logic [NUM_VARS-1:0] killVec,
  output logic                fullHit
);

  localparam int IDX_W    = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1;
  localparam int SPAN     = (PROG_LEN > 1) ? PROG_LEN - 1 : 1;
  localparam int MAX_STEP = (NUM_VARS > 1) ? (NUM_VARS - 1) / SPAN : 0;

  always_comb begin
    int cnt;
    logic [IDX_W-1:0] idx;
    killVec = '0;
    fullHit = 1'b0;
    cnt = 0;
    idx = '0;
    for (int d = 1; d <= MAX_STEP; d++) begin
      for (int s = 0; s + SPAN * d < NUM_VARS; s++) begin
        cnt = 0;
        for (int j = 0; j < PROG_LEN; j++) begin
          idx = IDX_W'(s + j * d);
          if (forced[idx]) cnt++;
        end
        if (cnt == PROG_LEN) fullHit = 1'b1;
        if (cnt == PROG_LEN - 1) begin
          for (int j = 0; j < PROG_LEN; j++) begin
            idx = IDX_W'(s + j * d);
            if (!forced[idx] && allow[idx]) killVec[idx] = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/apInferDatapath.sv
module apInferDatapath
  import apInferPkg::*;
#(
  parameter int NUM_VARS   = 32,
  parameter int NUM_COLORS = 3,
  parameter logic [NUM_COLORS-1:0][7:0] PROG_LEN = {NUM_COLORS{8'd4}},
  localparam int COLOR_W = (NUM_COLORS > 1) ? $clog2(NUM_COLORS + 1) : 1,
  localparam int MASK_W  = NUM_VARS * NUM_COLORS
) (
  input  logic               clk,
  input  logic               rstN,
  input  apStrobe_t          strobe,
  input  logic [COLOR_W-1:0] colorSel,
  input  logic [MASK_W-1:0]  maskIn,
  output logic [MASK_W-1:0]  maskOut,
  output logic               changed,
  output logic               conflict
);

  logic                  colorValid;
  logic [NUM_COLORS-1:0] selHot;
  logic [NUM_VARS-1:0]   forced;
  logic [NUM_VARS-1:0]   allow;
  logic [NUM_VARS-1:0]   killG [NUM_COLORS];
  logic [NUM_COLORS-1:0] fullG;
  logic [NUM_VARS-1:0]   killSel;
  logic                  fullSel;
  logic [MASK_W-1:0]     newMask;
  logic [NUM_VARS-1:0]   zeroVec;

  assign colorValid = int'(colorSel) < NUM_COLORS;
  assign selHot     = colorValid ? (NUM_COLORS'(1) << colorSel) : '0;

  // Per-variable view of the selected color.
  for (genvar i = 0; i < NUM_VARS; i++) begin : gVar
    logic [NUM_COLORS-1:0] slice;
    assign slice      = maskIn[i*NUM_COLORS +: NUM_COLORS];
    assign forced[i]  = colorValid && (slice == selHot);
    assign allow[i]   = |(slice & selHot);
    assign newMask[i*NUM_COLORS +: NUM_COLORS] =
      slice & ~(selHot & {NUM_COLORS{killSel[i]}});
    assign zeroVec[i] = (newMask[i*NUM_COLORS +: NUM_COLORS] == '0);
  end

  // One scanner per color, each built for that color's length.
  for (genvar g = 0; g < NUM_COLORS; g++) begin : gColor
    apProgScan #(
      .NUM_VARS (NUM_VARS),
      .PROG_LEN (int'(PROG_LEN[g]))
    ) uScan (
      .forced  (forced),
      .allow   (allow),
      .killVec (killG[g]),
      .fullHit (fullG[g])
    );
  end

  always_comb begin
    killSel = '0;
    fullSel = 1'b0;
    for (int g = 0; g < NUM_COLORS; g++) begin
      if (int'(colorSel) == g) begin
        killSel = killG[g];
        fullSel = fullG[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskOut  <= '0;
      changed  <= 1'b0;
      conflict <= 1'b0;
    end else if (strobe.load) begin
      maskOut  <= newMask;
      changed  <= |killSel;
      conflict <= fullSel | (|zeroVec);
    end
  end

endmodule

// File: rtl/apInferControl.sv
module apInferControl
  import apInferPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output apStrobe_t strobe,
  output logic      done
);

  always_comb begin
    strobe      = '0;
    strobe.load = start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

endmodule

// File: rtl/apInferUnit.sv
module apInferUnit
  import apInferPkg::*;
#(
  parameter int NUM_VARS   = 32,
  parameter int NUM_COLORS = 3,
  parameter logic [NUM_COLORS-1:0][7:0] PROG_LEN = {NUM_COLORS{8'd4}},
  localparam int COLOR_W = (NUM_COLORS > 1) ? $clog2(NUM_COLORS + 1) : 1,
  localparam int MASK_W  = NUM_VARS * NUM_COLORS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COLOR_W-1:0] colorSel,
  input  logic [MASK_W-1:0]  maskIn,
  output logic [MASK_W-1:0]  maskOut,
  output logic               changed,
  output logic               conflict,
  output logic               done
);

  apStrobe_t strobe;

  apInferControl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  apInferDatapath #(
    .NUM_VARS   (NUM_VARS),
    .NUM_COLORS (NUM_COLORS),
    .PROG_LEN   (PROG_LEN)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .colorSel (colorSel),
    .maskIn   (maskIn),
    .maskOut  (maskOut),
    .changed  (changed),
    .conflict (conflict)
  );

endmodule

// File: rtl/apInferChecker.sv
module apInferChecker #(
  parameter int NUM_VARS   = 32,
  parameter int NUM_COLORS = 3,
  parameter int COLOR_W    = 2,
  localparam int MASK_W    = NUM_VARS * NUM_COLORS
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [COLOR_W-1:0] colorSel,
  input logic [MASK_W-1:0]  maskIn,
  input logic [MASK_W-1:0]  maskOut,
  input logic               changed,
  input logic               conflict,
  input logic               done
);

  logic [MASK_W-1:0] selRep;
  logic              selValid;
  logic              anyEmpty;

  always_comb begin
    selRep   = '0;
    selValid = int'(colorSel) < NUM_COLORS;
    anyEmpty = 1'b0;
    for (int i = 0; i < NUM_VARS; i++) begin
      for (int c = 0; c < NUM_COLORS; c++)
        if (int'(colorSel) == c) selRep[i*NUM_COLORS + c] = 1'b1;
      if (maskOut[i*NUM_COLORS +: NUM_COLORS] == '0) anyEmpty = 1'b1;
    end
  end

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(maskOut) && $stable(changed) && $stable(conflict) && !done));

  // R5
  only_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((maskOut & ~$past(maskIn)) == '0));

  // R5
  other_colors_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (((maskOut ^ $past(maskIn)) & ~$past(selRep)) == '0));

  // R6
  changed_matches_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (changed == (maskOut != $past(maskIn))));

  // R8
  empty_mask_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && anyEmpty) |-> conflict);

  // R10
  bad_color_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(selValid)) |-> (maskOut == $past(maskIn) && !changed));

endmodule

bind apInferUnit apInferChecker #(
  .NUM_VARS   (NUM_VARS),
  .NUM_COLORS (NUM_COLORS),
  .COLOR_W    (COLOR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .colorSel (colorSel),
  .maskIn   (maskIn),
  .maskOut  (maskOut),
  .changed  (changed),
  .conflict (conflict),
  .done     (done)
);

// File: tb/apInferUnit_test.sv
module apInferUnit_test;

  localparam int N  = 32;
  localparam int K  = 3;
  localparam int CW = 2;
  localparam int MW = N * K;
  localparam int LENS [K] = '{3, 4, 5};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] colorSel = '0;
  logic [MW-1:0] maskIn = '0;
  logic [MW-1:0] maskOut;
  logic          changed, conflict, done;

  int checks = 0;
  int fails  = 0;

  logic [MW-1:0] expMask;
  logic          expChanged, expConflict;

  always #5 clk = ~clk;

  apInferUnit #(
    .NUM_VARS   (N),
    .NUM_COLORS (K),
    .PROG_LEN   ({8'd5, 8'd4, 8'd3})
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .colorSel (colorSel),
    .maskIn   (maskIn),
    .maskOut  (maskOut),
    .changed  (changed),
    .conflict (conflict),
    .done     (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [K-1:0] slot(input logic [MW-1:0] m, input int i);
    return m[i*K +: K];
  endfunction

  // Reference model: per variable, look at every progression through it.
  task automatic model(input logic [MW-1:0] m, input int c);
    bit isF [N];
    int len;
    expMask = m;
    expChanged = 1'b0;
    expConflict = 1'b0;
    if (c < K) begin
      len = LENS[c];
      for (int i = 0; i < N; i++) isF[i] = (slot(m, i) == K'(1 << c));
      for (int i = 0; i < N; i++) begin
        if (!isF[i] && m[i*K + c]) begin
          for (int d = 1; d < N; d++) begin
            for (int k = 0; k < len; k++) begin
              int s = i - k * d;
              if (s >= 0 && s + (len - 1) * d < N) begin
                bit others = 1'b1;
                for (int j = 0; j < len; j++)
                  if (j != k && !isF[s + j * d]) others = 1'b0;
                if (others) expMask[i*K + c] = 1'b0;
              end
            end
          end
        end
      end
      for (int d = 1; d < N; d++)
        for (int s = 0; s + (len - 1) * d < N; s++) begin
          bit all = 1'b1;
          for (int j = 0; j < len; j++) if (!isF[s + j * d]) all = 1'b0;
          if (all) expConflict = 1'b1;
        end
    end
    expChanged = (expMask != m);
    for (int i = 0; i < N; i++) if (slot(expMask, i) == '0) expConflict = 1'b1;
  endtask

  task automatic runPass(input logic [MW-1:0] m, input int c, input string req);
    @(negedge clk);
    maskIn = m;
    colorSel = CW'(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model(m, c);
    check(done == 1'b1, req, "done pulse", MW'(done), MW'(1));
    check(maskOut == expMask, req, "maskOut", maskOut, expMask);
    check(changed == expChanged, req, "changed", MW'(changed), MW'(expChanged));
    check(conflict == expConflict, req, "conflict", MW'(conflict), MW'(expConflict));
  endtask

  function automatic logic [MW-1:0] allFree();
    logic [MW-1:0] m;
    for (int i = 0; i < N; i++) m[i*K +: K] = '1;
    return m;
  endfunction

  function automatic logic [K-1:0] pickMask();
    int r = int'($urandom % 20);
    if (r == 0) return 3'b000;
    if (r < 6)  return 3'b001;
    if (r < 10) return 3'b010;
    if (r < 14) return 3'b100;
    if (r == 14) return 3'b011;
    if (r == 15) return 3'b101;
    if (r == 16) return 3'b110;
    return 3'b111;
  endfunction

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [MW-1:0] m;
    logic [MW-1:0] held;
    void'($urandom(32'd7321));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(maskOut == '0 && !changed && !conflict && !done, "R1", "during reset",
          {maskOut[MW-4:0], changed, conflict, done}, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(maskOut == '0 && !changed && !conflict && !done, "R1", "after release",
          {maskOut[MW-4:0], changed, conflict, done}, '0);

    // R4, R3: nothing forced, nothing cleared
    runPass(allFree(), 0, "R4");

    // R4, R9: vars 0,1 forced to color 0 (mask 001), var 2 loses bit 0
    m = allFree();
    m[0*K +: K] = 3'b001;
    m[1*K +: K] = 3'b001;
    runPass(m, 0, "R4");
    check(slot(maskOut, 2) == 3'b110 && changed, "R4", "var2 narrowed",
          MW'(slot(maskOut, 2)), MW'(3'b110));

    // R9: same shape for color 1 (length 4) clears nothing
    m = allFree();
    m[0*K +: K] = 3'b010;
    m[1*K +: K] = 3'b010;
    runPass(m, 1, "R9");
    check(!changed, "R9", "length 4 ignores pair", MW'(changed), MW'(0));
    m[2*K +: K] = 3'b010;
    runPass(m, 1, "R9");
    check(slot(maskOut, 3) == 3'b101, "R9", "length 4 clears fourth",
          MW'(slot(maskOut, 3)), MW'(3'b101));

    // R4: upper boundary, vars 29,30 forced, var 31 cleared
    m = allFree();
    m[29*K +: K] = 3'b001;
    m[30*K +: K] = 3'b001;
    runPass(m, 0, "R4");
    check(slot(maskOut, 31) == 3'b110, "R4", "var31 narrowed",
          MW'(slot(maskOut, 31)), MW'(3'b110));

    // R7: vars 0,2,4 forced to color 0, step 2
    m = allFree();
    m[0*K +: K] = 3'b001;
    m[2*K +: K] = 3'b001;
    m[4*K +: K] = 3'b001;
    runPass(m, 0, "R7");
    check(conflict, "R7", "full progression", MW'(conflict), MW'(1));

    // R8: empty mask at var 31
    m = allFree();
    m[31*K +: K] = 3'b000;
    runPass(m, 1, "R8");
    check(conflict, "R8", "empty mask", MW'(conflict), MW'(1));

    // R10: out-of-range select passes through
    m = allFree();
    m[0*K +: K] = 3'b001;
    m[1*K +: K] = 3'b001;
    runPass(m, 3, "R10");
    check(maskOut == m && !changed, "R10", "passthrough", maskOut, m);

    // R2: hold without start
    held = maskOut;
    @(negedge clk);
    maskIn = ~maskIn;
    colorSel = 2'd0;
    @(negedge clk);
    check(maskOut == held && !done, "R2", "hold without start", maskOut, held);

    // R5, R6, R7, R8, R4: random arrays
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < N; i++) m[i*K +: K] = pickMask();
      runPass(m, int'($urandom % 4), "R5");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule